// File: doc/BRIEF.md
# Address-Sequence Configuration Unlocker

This block sits between an address decoder and a battery-backed static RAM. It holds two configuration switches. The write switch selects read/write or read-only operation. The retention switch turns power-fail protection on or off. Software cannot reach either switch through a register. The only way to change them is to run sixteen consecutive memory cycles whose low four address bits form a fixed code. The block samples those bits when the chip-enable input falls, and steps a compare pointer forward by one for each sampled word.

The same block also drives the RAM's chip-enable and write-enable, both active low. In read-only mode the write-enable output is held high. While the synchronised power-fail input is high and the retention switch is on, both outputs are held high. Gating of chip-enable is fixed for the whole of a memory cycle, so the output never glitches during an access. The inputs are synchronous to `clk_i`. There are two reset inputs. The supply reset `rst_ni` sets the write switch and the control path. The battery reset `bat_rst_ni` clears only the retention switch.

Top module: `addr_unlock_ctrl`

## Requirements
- R1: One address word is sampled per high-to-low transition of `ce_ni`, and the compare pointer advances by one per sampled word. Sixteen matching words in a row, pointer 0 to 15, commit new switch values.
- R2: A sampled word of 4'b1111 returns the pointer to 0. An attempt that is cut off this way never commits, and a full sequence that follows it does commit.
- R3: Bits [2:0] of word i must equal i mod 7 for i = 0..15. Bit 3 must match the pattern 0,1,1,0,1,0,0,1,1,0,1 for i = 0..10. Any mismatch returns the pointer to 0 and leaves both switches unchanged.
- R4: Bit 3 of word 11 becomes the write switch. With 1 (read/write), `we_no` follows `we_ni`. With 0 (read-only), `we_no` stays 1.
- R5: Bit 3 of words 12, 13, 14, 15 must read 1, 0, 1, 0 in that order to set the retention switch to 1. Any other combination sets it to 0.
- R6: Switch outputs change only in the clock after word 15 is sampled with every compare matched. Output gating picks up the new values from the next memory cycle.
- R7: `rst_ni` low sets the write switch to 1 (read/write) and the pointer to 0. `bat_rst_ni` low sets the retention switch to 0 and leaves the write switch unchanged.
- R8: With the retention switch at 1, a synchronised power-fail seen while `ce_ni` is high holds `ce_no` and `we_no` at 1 for the next cycle. With the retention switch at 0, `pf_i` has no effect on either output.
- R9: While `ce_ni` stays low, `ce_no` does not change. A power-fail that rises during a cycle forces `we_no` to 1 within three clocks when the retention switch is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Supply-power reset, active low, asynchronous |
| bat_rst_ni | input | 1 | Battery first-power reset, active low, asynchronous |
| ce_ni | input | 1 | Chip enable from decoder, active low |
| we_ni | input | 1 | Write enable from host, active low |
| addr_i | input | 4 | Low address bits 3..0 |
| pf_i | input | 1 | Power-fail flag, asynchronous |
| ce_no | output | 1 | Gated chip enable to RAM, active low |
| we_no | output | 1 | Gated write enable to RAM, active low |
| wr_en_o | output | 1 | Write switch: 1 read/write, 0 read-only |
| nv_en_o | output | 1 | Retention switch: 1 power-fail protection on |

## Verification
A commit of the retention switch and a held power-fail can land in the same memory cycle. The bench holds `pf_i` high while it walks a sequence that turns retention on. During the sixteenth cycle, `ce_no` must still follow `ce_ni`, because the old setting is still in force. From the next cycle on, `ce_no` must stay high. A second overlap is a power-fail that rises in the middle of an access. It is judged by checking that `ce_no` stays low until the cycle ends and that `we_no` is cut within three clocks.

// File: rtl/addr_unlock_pkg.sv
package addr_unlock_pkg;
  typedef struct packed {
    logic wr;  // 1 read/write, 0 read-only
    logic nv;  // 1 power-fail protection active
  } sw_t;
endpackage

// File: rtl/cu_front.sv
module cu_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic pf_i,
  output logic ce_fall_o,
  output logic pf_s_o
);
  logic                   ce_q;
  logic [SYNC_STAGES-1:0] pf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b1;
      pf_q <= '0;
    end else begin
      ce_q <= ce_ni;
      pf_q <= {pf_q[SYNC_STAGES-2:0], pf_i};
    end
  end

  assign ce_fall_o = ce_q & ~ce_ni;
  assign pf_s_o    = pf_q[SYNC_STAGES-1];

  a_r1_one_sample_per_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_fall_o |=> !ce_fall_o);
endmodule

// File: rtl/cu_matcher.sv
module cu_matcher
  import addr_unlock_pkg::*;
#(
  parameter int unsigned SEQ_LEN  = 16,
  parameter int unsigned CHK_HI   = 11,
  parameter int unsigned LO_W     = 3,
  parameter logic [SEQ_LEN-1:0][LO_W-1:0] EXP_LO = '0,
  parameter logic [CHK_HI-1:0] EXP_HI = '0,
  parameter logic [SEQ_LEN-CHK_HI-2:0] NV_KEY = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bat_rst_ni,
  input  logic            sample_i,
  input  logic [LO_W:0]   addr_i,
  output sw_t             sw_o
);
  localparam int unsigned PTR_W = $clog2(SEQ_LEN);
  localparam int unsigned NV_W  = SEQ_LEN - CHK_HI - 1;
  localparam logic [PTR_W-1:0] WR_IDX = PTR_W'(CHK_HI);
  localparam logic [PTR_W-1:0] LAST   = PTR_W'(SEQ_LEN - 1);

  logic [PTR_W-1:0]   ptr_q;
  logic               wr_tmp_q;
  logic [NV_W-1:0]    nv_tmp_q;
  logic               wr_q, nv_q;
  logic [SEQ_LEN-1:0] exp_hi_ext;
  logic               rst_word, lo_ok, hi_ok, match, commit;

  assign exp_hi_ext = {{(SEQ_LEN-CHK_HI){1'b0}}, EXP_HI};
  assign rst_word   = &addr_i;
  assign lo_ok      = addr_i[LO_W-1:0] == EXP_LO[ptr_q];
  assign hi_ok      = (ptr_q >= WR_IDX) || (addr_i[LO_W] == exp_hi_ext[ptr_q]);
  assign match      = ~rst_word & lo_ok & hi_ok;
  assign commit     = sample_i & match & (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      wr_tmp_q <= 1'b1;
      nv_tmp_q <= '0;
    end else if (sample_i) begin
      if (!match) begin
        ptr_q <= '0;
      end else begin
        if (ptr_q == WR_IDX) wr_tmp_q <= addr_i[LO_W];
        if (ptr_q > WR_IDX)  nv_tmp_q <= {nv_tmp_q[NV_W-2:0], addr_i[LO_W]};
        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wr_q <= 1'b1;
    else if (commit) wr_q <= wr_tmp_q;
  end

  // retention switch survives supply loss; only battery reset clears it
  always_ff @(posedge clk_i or negedge bat_rst_ni) begin
    if (!bat_rst_ni) nv_q <= 1'b0;
    else if (commit) nv_q <= ({nv_tmp_q[NV_W-2:0], addr_i[LO_W]} == NV_KEY);
  end

  assign sw_o.wr = wr_q;
  assign sw_o.nv = nv_q;

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && addr_i == '1) |=> ptr_q == '0);
  a_r3_abandon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !lo_ok) |=> ptr_q == '0);
  a_r6_wr_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q != $past(wr_q)) |-> ($past(sample_i) && $past(ptr_q) == LAST));
  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(ptr_q));
endmodule

// File: rtl/cu_gate.sv
module cu_gate
  import addr_unlock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic pf_s_i,
  input  sw_t  sw_i,
  output logic ce_no,
  output logic we_no
);
  logic wr_cur_q, nv_cur_q, ce_blk_q;

  // settings and chip-enable block reload only between accesses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cur_q <= 1'b1;
      nv_cur_q <= 1'b0;
      ce_blk_q <= 1'b0;
    end else if (ce_ni) begin
      wr_cur_q <= sw_i.wr;
      nv_cur_q <= sw_i.nv;
      ce_blk_q <= pf_s_i & sw_i.nv;
    end
  end

  assign ce_no = ce_ni | ce_blk_q;
  assign we_no = we_ni | ~wr_cur_q | ce_blk_q | (pf_s_i & nv_cur_q);

  a_r9_ce_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && $past(!ce_ni)) |-> ce_no == $past(ce_no));
  a_r8_pf_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ce_ni && pf_s_i && sw_i.nv) && !ce_ni) |-> (ce_no && we_no));
  a_r4_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ce_ni && !sw_i.wr) && !ce_ni) |-> we_no);
endmodule

// File: rtl/addr_unlock_ctrl.sv
module addr_unlock_ctrl
  import addr_unlock_pkg::*;
#(
  parameter int unsigned SEQ_LEN = 16,
  parameter int unsigned CHK_HI  = 11,
  parameter int unsigned LO_W    = 3,
  parameter logic [SEQ_LEN-1:0][LO_W-1:0] EXP_LO = {
    3'd1, 3'd0, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1,
    3'd0, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [CHK_HI-1:0] EXP_HI = 11'b101_1001_0110,
  parameter logic [SEQ_LEN-CHK_HI-2:0] NV_KEY = 4'b1010
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bat_rst_ni,
  input  logic            ce_ni,
  input  logic            we_ni,
  input  logic [LO_W:0]   addr_i,
  input  logic            pf_i,
  output logic            ce_no,
  output logic            we_no,
  output logic            wr_en_o,
  output logic            nv_en_o
);
  logic ce_fall, pf_s;
  sw_t  sw;

  initial begin
    for (int i = 0; i < int'(SEQ_LEN); i++)
      a_r2_no_reset_word: assert (EXP_LO[i] != '1);
  end

  cu_front #(.SYNC_STAGES(2)) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .pf_i     (pf_i),
    .ce_fall_o(ce_fall),
    .pf_s_o   (pf_s)
  );

  cu_matcher #(
    .SEQ_LEN(SEQ_LEN), .CHK_HI(CHK_HI), .LO_W(LO_W),
    .EXP_LO(EXP_LO), .EXP_HI(EXP_HI), .NV_KEY(NV_KEY)
  ) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bat_rst_ni(bat_rst_ni),
    .sample_i  (ce_fall),
    .addr_i    (addr_i),
    .sw_o      (sw)
  );

  cu_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (ce_ni),
    .we_ni (we_ni),
    .pf_s_i(pf_s),
    .sw_i  (sw),
    .ce_no (ce_no),
    .we_no (we_no)
  );

  assign wr_en_o = sw.wr;
  assign nv_en_o = sw.nv;
endmodule

// File: tb/addr_unlock_ctrl_test.sv
module addr_unlock_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, bat_rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, pf = 1'b0;
  logic [3:0] addr = 4'h0;
  logic ce_o, we_o, wr_o, nv_o;
  int checks = 0, errors = 0;

  localparam logic [10:0] HI_BITS = 11'b10110010110;
  // words for: write switch 0, retention key 1010
  localparam logic [3:0] SEQ_A [16] = '{
    4'h0, 4'h9, 4'hA, 4'h3, 4'hC, 4'h5, 4'h6, 4'h8,
    4'h9, 4'h2, 4'hB, 4'h4, 4'hD, 4'h6, 4'h8, 4'h1};

  always #5 clk = ~clk;

  addr_unlock_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bat_rst_ni(bat_rst_n),
    .ce_ni(ce_n), .we_ni(we_n), .addr_i(addr), .pf_i(pf),
    .ce_no(ce_o), .we_no(we_o), .wr_en_o(wr_o), .nv_en_o(nv_o));

  function automatic logic [3:0] word(int i, logic wr, logic [3:0] nv);
    logic a3;
    if (i < 11)       a3 = HI_BITS[i];
    else if (i == 11) a3 = wr;
    else              a3 = nv[15-i];
    return {a3, 3'(i % 7)};
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [3:0] a, logic do_wr);
    @(negedge clk); addr = a; ce_n = 1'b0;
    @(negedge clk); we_n = ~do_wr;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_seq(logic wr, logic [3:0] nv);
    for (int i = 0; i < 16; i++) cyc(word(i, wr, nv), 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset ce_no", {3'b0, ce_o}, 4'h1);
    chk("R7 reset we_no", {3'b0, we_o}, 4'h1);
    chk("R7 reset write switch", {3'b0, wr_o}, 4'h1);
    chk("R7 reset retention", {3'b0, nv_o}, 4'h0);
    rst_n = 1'b1; bat_rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 read/write passthrough
    ce_n = 1'b0; we_n = 1'b0; @(negedge clk);
    chk("R4 rw ce_no", {3'b0, ce_o}, 4'h0);
    chk("R4 rw we_no", {3'b0, we_o}, 4'h0);
    ce_n = 1'b1; we_n = 1'b1; @(negedge clk);

    // R8 power-fail ignored while retention off
    pf = 1'b1; repeat (4) @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; @(negedge clk);
    chk("R8 pf ignored ce_no", {3'b0, ce_o}, 4'h0);
    chk("R8 pf ignored we_no", {3'b0, we_o}, 4'h0);
    ce_n = 1'b1; we_n = 1'b1; pf = 1'b0; repeat (4) @(negedge clk);

    // R1 R5 R6 table walk
    for (int i = 0; i < 16; i++) begin
      cyc(SEQ_A[i], 1'b0);
      if (i == 14) chk("R6 no early commit", {2'b0, wr_o, nv_o}, 4'b0010);
    end
    chk("R1 R5 committed", {2'b0, wr_o, nv_o}, 4'b0001);

    // R4 read-only
    ce_n = 1'b0; we_n = 1'b0; @(negedge clk);
    chk("R4 ro ce_no", {3'b0, ce_o}, 4'h0);
    chk("R4 ro we_no", {3'b0, we_o}, 4'h1);
    ce_n = 1'b1; we_n = 1'b1; @(negedge clk);

    run_seq(1'b1, 4'b1011);
    chk("R5 bad key", {2'b0, wr_o, nv_o}, 4'b0010);
    run_seq(1'b1, 4'b1010);
    chk("R1 rw plus retention", {2'b0, wr_o, nv_o}, 4'b0011);

    // R9 power-fail mid-access
    @(negedge clk); addr = 4'h7; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); pf = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 ce_no held in cycle", {3'b0, ce_o}, 4'h0);
    chk("R9 we_no cut", {3'b0, we_o}, 4'h1);
    ce_n = 1'b1; we_n = 1'b1; @(negedge clk);
    ce_n = 1'b0; @(negedge clk);
    chk("R8 pf blocks ce_no", {3'b0, ce_o}, 4'h1);
    ce_n = 1'b1; pf = 1'b0; repeat (4) @(negedge clk);
    ce_n = 1'b0; @(negedge clk);
    chk("R8 pf cleared ce_no", {3'b0, ce_o}, 4'h0);
    ce_n = 1'b1; @(negedge clk);

    // R3 low-bit mismatch at cycle 5
    for (int i = 0; i < 16; i++) cyc(word(i, 1'b0, 4'b0000) ^ ((i == 5) ? 4'h1 : 4'h0), 1'b0);
    chk("R3 low mismatch", {2'b0, wr_o, nv_o}, 4'b0011);
    // R3 bit-3 mismatch at cycle 3
    for (int i = 0; i < 16; i++) cyc(word(i, 1'b0, 4'b0000) ^ ((i == 3) ? 4'h8 : 4'h0), 1'b0);
    chk("R3 bit3 mismatch", {2'b0, wr_o, nv_o}, 4'b0011);

    // R2 restart word
    for (int i = 0; i < 8; i++) cyc(word(i, 1'b0, 4'b0000), 1'b0);
    cyc(4'hF, 1'b0);
    for (int i = 8; i < 16; i++) cyc(word(i, 1'b0, 4'b0000), 1'b0);
    chk("R2 cut attempt", {2'b0, wr_o, nv_o}, 4'b0011);
    for (int i = 0; i < 8; i++) cyc(word(i, 1'b0, 4'b0000), 1'b0);
    cyc(4'hF, 1'b0);
    run_seq(1'b0, 4'b0000);
    chk("R2 restart commit", {2'b0, wr_o, nv_o}, 4'b0000);

    // R7 reset domains
    run_seq(1'b0, 4'b1010);
    bat_rst_n = 1'b0; @(negedge clk); bat_rst_n = 1'b1; @(negedge clk);
    chk("R7 battery reset", {2'b0, wr_o, nv_o}, 4'b0000);
    run_seq(1'b0, 4'b1010);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R7 supply reset", {2'b0, wr_o, nv_o}, 4'b0011);

    // R6 R8 commit with power-fail held
    bat_rst_n = 1'b0; @(negedge clk); bat_rst_n = 1'b1;
    pf = 1'b1; repeat (4) @(negedge clk);
    for (int i = 0; i < 15; i++) cyc(word(i, 1'b1, 4'b1010), 1'b0);
    @(negedge clk); addr = word(15, 1'b1, 4'b1010); ce_n = 1'b0;
    @(negedge clk);
    chk("R6 old setting in last cycle", {3'b0, ce_o}, 4'h0);
    ce_n = 1'b1; @(negedge clk);
    chk("R6 commit under pf", {2'b0, wr_o, nv_o}, 4'b0011);
    ce_n = 1'b0; @(negedge clk);
    chk("R8 next cycle blocked", {3'b0, ce_o}, 4'h1);
    ce_n = 1'b1; pf = 1'b0; repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule